// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs one clause-22 management transaction on the two-wire station management bus each time software writes a 32-bit word to it. The written word is itself the frame image. Bits [31:30] hold the start code and bits [29:28] the opcode. Bits [27:23] carry the PHY address and bits [22:18] the register address. Bits [17:16] hold the turnaround code and bits [15:0] the data. The controller first sends a preamble of ones. It then shifts the word out MSB first, with no separate command fields to decode. A read request uses start 01, opcode 10 and turnaround 10 (0x60020000 with the addresses OR-ed in). A write request uses start 01, opcode 01 and turnaround 10 (0x50020000 with the data in the low half).

The management clock is made from the system clock by a divider parameter. With the defaults at a 50 MHz system clock it runs at 2.5 MHz. The controller changes the data line on falling management-clock edges and samples it on rising edges. For a read it releases the line from the second turnaround bit onward. It captures the PHY's 16 data bits and writes them into the low half of the stored word. A one-cycle completion pulse marks the end of every transaction. A status unit elsewhere latches that pulse. The data pin is exposed as an output value, an output enable and an input, which a pad cell combines into the bidirectional pin.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, busy, done, mdc and mdio_oe are 0 and reg_word is 0.
- R2: A write strobe while busy is 0 stores wr_data in reg_word and raises busy on the next cycle. The first PRE_LEN (32) bit times then carry mdio_oe=1 and mdio_out=1.
- R3: After the preamble, the 32 bits of the stored word are presented MSB first, bit 31 first and bit 0 last, one per management-clock cycle.
- R4: mdc is low while idle and has a period of 2*HALF_DIV system clocks (20 by default). mdio_out and mdio_oe change during a frame only on the cycle in which mdc falls.
- R5: When word bits [29:28] equal 10 (read), mdio_oe is 0 from word bit 16 (the second turnaround bit) through bit 0. Any other opcode value drives all 32 frame bits.
- R6: In a read, mdio_in is sampled at the 16 rising mdc edges of the data bits, MSB first. At the end of the frame the sampled value replaces reg_word[15:0], and reg_word[31:16] is kept.
- R7: A frame whose opcode is not 10 leaves reg_word unchanged.
- R8: A frame lasts exactly 64 mdc cycles (128*HALF_DIV system clocks of busy). done pulses for exactly one cycle, in the same cycle that busy falls.
- R9: A write strobe while busy is 1 is ignored. reg_word keeps its value, and the frame under way neither restarts nor lengthens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Frame image to send |
| reg_word | output | 32 | Stored word; low half holds read data after a read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data value to the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_in | input | 1 | Data value from the pad |

## Verification
Busy rises one cycle after the accepted strobe and stays high for exactly 1280 system cycles with the defaults. The first mdc rise comes 10 cycles after acceptance. Done and the updated reg_word appear together on the cycle busy falls. The bench samples every output at the falling system-clock edge, counts busy cycles and rise-to-rise spacing, and records the data line at each observed mdc rise. It then compares the record against the bit sequence computed from the written word. The model PHY changes mdio_in only just after it sees mdc fall, which leaves a full half period of setup before the sampling rise.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_W   = 32;
    localparam int DATA_W    = 16;
    localparam logic [1:0] OP_READ = 2'b10;

    function automatic logic is_read(input logic [FRAME_W-1:0] w);
        return w[29:28] == OP_READ;
    endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t q, d;
    logic tick;

    always_comb begin
        d    = q;
        tick = run && (q.cnt == TERM);
        if (!run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (tick) begin
            d.cnt = '0;
            d.mdc = !q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc       = q.mdc;
    assign rise_tick = tick && !q.mdc;
    assign fall_tick = tick && q.mdc;

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !q.mdc) else $error("mdc high while idle"); // R4
    AST_MDC_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && q.cnt != TERM) |=> $stable(q.mdc)) else $error("mdc toggled early"); // R4
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               mdio_in,
    output logic               busy,
    output logic               done,
    output logic [FRAME_W-1:0] word,
    output logic               mdio_out,
    output logic               mdio_oe
);
    localparam int TOTAL   = PRE_LEN + FRAME_W;
    localparam int IDX_W   = $clog2(TOTAL);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
    localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(PRE_LEN + FRAME_W - DATA_W - 1);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_LEN + FRAME_W - DATA_W);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic               rd;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] word;
        logic [DATA_W-1:0]  shreg;
        logic               mdo;
        logic               oe;
    } eng_t;

    eng_t q, d;

    // {oe, value} for bit time n of the frame
    function automatic logic [1:0] bit_drive(input logic [IDX_W-1:0] n,
                                             input logic [FRAME_W-1:0] w,
                                             input logic rd);
        int pos;
        if (int'(n) < PRE_LEN) return 2'b11;
        if (rd && n >= REL_IDX) return 2'b01;
        pos = TOTAL - 1 - int'(n);
        return {1'b1, w[pos[4:0]]};
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (wr_en) begin
                d.busy  = 1'b1;
                d.word  = wr_data;
                d.rd    = is_read(wr_data);
                d.idx   = '0;
                d.shreg = '0;
                d.mdo   = 1'b1;
                d.oe    = 1'b1;
            end
        end else begin
            if (rise_tick && q.rd && q.idx >= DAT_IDX)
                d.shreg = {q.shreg[DATA_W-2:0], mdio_in};
            if (fall_tick) begin
                if (q.idx == LAST_IDX) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                    d.oe   = 1'b0;
                    d.mdo  = 1'b1;
                    if (q.rd) d.word[DATA_W-1:0] = q.shreg;
                end else begin
                    d.idx           = q.idx + 1'b1;
                    {d.oe, d.mdo}   = bit_drive(q.idx + 1'b1, q.word, q.rd);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.mdo <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign word     = q.word;
    assign mdio_out = q.mdo;
    assign mdio_oe  = q.oe;

    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && wr_en && !fall_tick) |=> $stable(q.word)) else $error("write accepted while busy"); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done) else $error("done longer than one cycle"); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !q.busy) else $error("done while busy"); // R8
    AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && int'(q.idx) < PRE_LEN) |-> (mdio_oe && mdio_out)) else $error("preamble bit not one"); // R2
    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !fall_tick) |=> ($stable(q.mdo) && $stable(q.oe))) else $error("pin changed off falling edge"); // R4
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.rd && q.idx > REL_IDX) |-> !mdio_oe) else $error("pin driven during read data"); // R5
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
    parameter int HALF_DIV = 10,
    parameter int PRE_LEN  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] reg_word,
    output logic        busy,
    output logic        done,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic rise_tick;
    logic fall_tick;

    mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .busy      (busy),
        .done      (done),
        .word      (reg_word),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe)
    );
endmodule

// File: tb/mdio_frame_ctrl_bench.sv
module mdio_frame_ctrl_bench;
    localparam int HALF   = 10;
    localparam int NBITS  = 64;
    localparam int BUSY_CYC = NBITS * 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] reg_word;
    logic        busy, done, mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    mdio_frame_ctrl u_mdio_frame_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .reg_word(reg_word), .busy(busy), .done(done), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // monitor / PHY model state
    int   cyc = 0;
    int   nbit = 0;
    logic rec_o [NBITS];
    logic rec_oe[NBITS];
    int   last_rise = 0;
    int   min_per = 0;
    int   max_per = 0;
    int   viol = 0;
    logic [15:0] phy_data = '0;
    logic prev_mdc = 0, prev_o = 1, prev_oe = 0, prev_busy = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mdc && !prev_mdc) begin
                if (nbit < NBITS) begin
                    rec_o[nbit]  = mdio_out;
                    rec_oe[nbit] = mdio_oe;
                end
                if (nbit > 0) begin
                    if (cyc - last_rise < min_per) min_per = cyc - last_rise;
                    if (cyc - last_rise > max_per) max_per = cyc - last_rise;
                end
                last_rise = cyc;
                nbit++;
            end
            if (!mdc && prev_mdc)
                mdio_in = (nbit >= 48 && nbit < NBITS) ? phy_data[15 - (nbit - 48)] : 1'b1;
            if (prev_busy && busy && (mdio_out != prev_o || mdio_oe != prev_oe) && !(prev_mdc && !mdc))
                viol++;
        end
        prev_mdc  = mdc;
        prev_o    = mdio_out;
        prev_oe   = mdio_oe;
        prev_busy = busy;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    // One full transaction; inject=1 fires a second write mid-frame (R9)
    task automatic run_frame(input logic [31:0] w, input logic [15:0] phy, input bit inject, input string tag);
        int  bcyc;
        int  dones_busy;
        bit  done_at_fall;
        bit  rd;
        logic [31:0] exp_word;
        rd = (w[29:28] == 2'b10);
        exp_word = rd ? {w[31:16], phy} : w;
        nbit = 0; min_per = 1 << 20; max_per = 0; viol = 0;
        phy_data = phy;
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0;
        chk(busy === 1'b1, {tag, " R2 busy after accept"}, 32'(busy), 32'd1);
        chk(reg_word === w, {tag, " R2 word stored"}, reg_word, w);
        bcyc = 1; dones_busy = 0; done_at_fall = 0;
        while (busy && bcyc < 5000) begin
            if (inject && bcyc == 300) begin wr_en = 1'b1; wr_data = ~w; end
            @(negedge clk);
            if (inject && bcyc == 300) begin
                wr_en = 1'b0;
                chk(reg_word === w, {tag, " R9 word kept on busy write"}, reg_word, w);
            end
            if (busy) begin
                bcyc++;
                if (done) dones_busy++;
            end else begin
                done_at_fall = done;
            end
        end
        chk(bcyc == BUSY_CYC, {tag, " R8 busy length"}, 32'(bcyc), 32'(BUSY_CYC));
        chk(done_at_fall && dones_busy == 0, {tag, " R8 done with busy fall"}, 32'(done_at_fall), 32'd1);
        @(negedge clk);
        chk(done === 1'b0, {tag, " R8 done one cycle"}, 32'(done), 32'd0);
        chk(nbit == NBITS, {tag, " R8 mdc cycle count"}, 32'(nbit), 32'(NBITS));
        chk(min_per == 2*HALF && max_per == 2*HALF, {tag, " R4 mdc period"}, 32'(max_per), 32'(2*HALF));
        chk(viol == 0, {tag, " R4 pin change off falling edge"}, 32'(viol), 32'd0);
        chk(mdc === 1'b0 && mdio_oe === 1'b0, {tag, " R4 idle pins"}, {30'd0, mdc, mdio_oe}, 32'd0);
        for (int i = 0; i < 32; i++)
            chk(rec_o[i] === 1'b1 && rec_oe[i] === 1'b1, {tag, " R2 preamble bit"}, 32'(i), 32'd1);
        for (int i = 32; i < NBITS; i++) begin
            if (rd && i >= 47)
                chk(rec_oe[i] === 1'b0, {tag, " R5 released bit"}, 32'(i), 32'd0);
            else
                chk(rec_oe[i] === 1'b1 && rec_o[i] === w[63 - i], {tag, " R3 frame bit"},
                    {31'd0, rec_o[i]}, {31'd0, w[63 - i]});
        end
        if (rd) chk(reg_word === exp_word, {tag, " R6 read data stored"}, reg_word, exp_word);
        else    chk(reg_word === exp_word, {tag, " R7 word unchanged"}, reg_word, exp_word);
    endtask

    task automatic test_reset();
        chk(busy === 1'b0 && done === 1'b0, "R1 busy/done at reset", {30'd0, busy, done}, 32'd0);
        chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1 mdc/oe at reset", {30'd0, mdc, mdio_oe}, 32'd0);
        chk(reg_word === 32'd0, "R1 word at reset", reg_word, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        test_reset();
        // write: phy 3, reg 17, data BEEF
        run_frame(32'h5002_0000 | (32'd3 << 23) | (32'd17 << 18) | 32'h0000_BEEF, 16'h0000, 0, "write");
        // read: phy 1, reg 2
        run_frame(32'h6002_0000 | (32'd1 << 23) | (32'd2 << 18), 16'hA5C3, 0, "read");
        // read edge patterns
        run_frame(32'h6002_0000 | (32'd31 << 23) | (32'd31 << 18) | 32'h0000_FFFF, 16'h0001, 0, "read_lsb");
        run_frame(32'h6002_0000, 16'h8000, 0, "read_msb");
        // opcode 00: whole frame driven
        run_frame(32'h4002_1234, 16'hFFFF, 0, "op00");
        // busy write ignored
        run_frame(32'h5002_0000 | (32'd5 << 23) | 32'h0000_5A5A, 16'h0000, 1, "busy_wr");
        run_frame(32'h6002_0000 | (32'd9 << 23), 16'h3C96, 1, "busy_rd");
        finish_run();
    end
endmodule